// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns bytes, or 9-bit characters, written by a host into asynchronous serial frames on a single output line. Each frame has a low start bit, the data bits with the least significant bit first, and a high stop bit. A one-deep holding register sits in front of the shift register. The host can therefore queue the next character while the current one is still going out. Consecutive characters leave the line with no idle time between them.

Two flags report progress. The empty flag shows that the holding register can take a new character. The complete flag shows that the line has gone quiet after a stop bit. Each flag drives an interrupt request line. That line is qualified by the flag's own enable and by a global enable.

Bit timing comes from a divisor input: every bit lasts `baud_div + 1` clock cycles. The enable input does not stop the transmitter abruptly. When it drops, the character in the shift register and any character still queued are sent in full. Only after that does the line stay at the mark level and ignore further writes.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `empty_flag` is 1, `done_flag` is 0 and both interrupt requests are 0.
- R2: With `mode9` = 0 at the write, a frame is one 0 start bit, then the 8 bits of `wr_data` starting with bit 0, then one 1 stop bit. Every bit lasts `baud_div + 1` clock cycles.
- R3: With `mode9` = 1 at the write, the frame carries 9 data bits. The ninth bit is the value of `bit8_in` at the write, and it is sent after `wr_data[7]` and before the stop bit.
- R4: A write to an idle transmitter is taken at clock edge k. The line goes low as the start bit after edge k+1.
- R5: An accepted write clears `empty_flag` at the edge that takes it. `empty_flag` sets again at the edge where the character moves into the shift register.
- R6: A character waiting in the holding register starts at the edge that ends the previous stop bit. No idle cycle is inserted.
- R7: `done_flag` sets at the edge that ends a stop bit when no character is waiting. It clears when a new character starts, or one edge after a `done_clr` pulse.
- R8: `irq_empty` equals `empty_flag` AND `ie_empty` AND `gie`.
- R9: `irq_done` equals `done_flag` AND `ie_done` AND `gie`.
- R10: If `tx_enable` drops while a character is shifting and another is queued, both are sent completely. Only then does the line return to 1.
- R11: While `tx_enable` is 0 and nothing is shifting or queued, `txd` stays 1. A write has no effect: `empty_flag` stays 1 and no frame appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | DIV_W | Bit period minus one, in clock cycles |
| tx_enable | input | 1 | Transmitter enable (graceful when cleared) |
| mode9 | input | 1 | 9-bit character mode, sampled at the write |
| bit8_in | input | 1 | Ninth data bit, sampled at the write |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Host write data |
| done_clr | input | 1 | Pulse to clear the complete flag |
| ie_empty | input | 1 | Interrupt enable for the empty flag |
| ie_done | input | 1 | Interrupt enable for the complete flag |
| gie | input | 1 | Global interrupt enable |
| txd | output | 1 | Serial output, 1 when idle |
| empty_flag | output | 1 | Holding register can accept a character |
| done_flag | output | 1 | Transmission complete, line idle |
| irq_empty | output | 1 | Empty interrupt request |
| irq_done | output | 1 | Complete interrupt request |

## Verification
The frame format is swept over every 8-bit value at the shortest bit period and every 9-bit value at a two-cycle period. This separates bit-order and ninth-bit errors from timing errors. A smaller stride of values at divisors 0 to 4 shows whether each bit holds for exactly `baud_div + 1` cycles. Streaming writes, issued as soon as the empty flag rises, compare start-bit spacing against the frame length, which exposes any idle gap. Separate single-write, disable-while-queued and disabled-write sequences tell the latency, drain and ignore behaviour apart. All eight enable combinations are tried with each flag both set and clear.

// File: rtl/dbuf_uart_tx_pkg.sv
package dbuf_uart_tx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 3;          // start + data + ninth + stop
    localparam int IDX_W   = $clog2(FRAME_W);

    typedef struct packed {
        logic              nine;                  // 9-bit character
        logic              extra;                 // ninth data bit
        logic [DATA_W-1:0] payload;
    } tx_char_t;

    typedef enum logic {SH_IDLE, SH_SEND} sh_state_e;

    // Frame image, bit 0 goes out first; unused upper bits are mark level.
    function automatic logic [FRAME_W-1:0] build_frame(tx_char_t c);
        logic [FRAME_W-1:0] f;
        f              = '1;
        f[0]           = 1'b0;
        f[DATA_W:1]    = c.payload;
        f[DATA_W+1]    = c.nine ? c.extra : 1'b1;
        return f;
    endfunction

    // Index of the stop bit within the frame image.
    function automatic logic [IDX_W-1:0] stop_index(logic nine);
        return nine ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2);
    endfunction

endpackage

// File: rtl/dbuf_uart_tx_baud.sv
module dbuf_uart_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/dbuf_uart_tx_hold.sv
module dbuf_uart_tx_hold
    import dbuf_uart_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  tx_char_t wr_char,
    input  logic     tx_enable,
    input  logic     shifting,
    input  logic     finish,
    input  logic     done_clr,
    output logic     load,
    output tx_char_t q,
    output logic     empty,
    output logic     done
);

    logic full;
    logic accept;

    // Writes are taken while enabled, or while earlier characters still drain.
    assign accept = wr_en && (tx_enable || shifting || full);
    assign load   = full && (!shifting || finish);
    assign empty  = !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            q    <= '0;
        end else begin
            if (accept) begin
                full <= 1'b1;
                q    <= wr_char;
            end else if (load) begin
                full <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        done <= 1'b0;
        else if (finish && !full)       done <= 1'b1;
        else if (load || done_clr)      done <= 1'b0;
    end

    assert_write_fills_R5: assert property (@(posedge clk) disable iff (rst)
        accept |=> !empty);

    assert_queue_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (full && !tx_enable) |=> (full || shifting));

    assert_start_clears_done_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> !done);

endmodule

// File: rtl/dbuf_uart_tx_shift.sv
module dbuf_uart_tx_shift
    import dbuf_uart_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  tx_char_t ch,
    input  logic     tick,
    output logic     shifting,
    output logic     finish,
    output logic     txd
);

    sh_state_e          st;
    logic [FRAME_W-1:0] sr;
    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   last;

    assign shifting = (st == SH_SEND);
    assign finish   = shifting && tick && (idx == last);
    assign txd      = shifting ? sr[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SH_IDLE;
            sr   <= '1;
            idx  <= '0;
            last <= '0;
        end else if (load) begin
            st   <= SH_SEND;
            sr   <= build_frame(ch);
            idx  <= '0;
            last <= stop_index(ch.nine);
        end else if (finish) begin
            st   <= SH_IDLE;
            sr   <= '1;
        end else if (shifting && tick) begin
            sr   <= {1'b1, sr[FRAME_W-1:1]};
            idx  <= idx + 1'b1;
        end
    end

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> !txd);

    assert_stop_high_R2: assert property (@(posedge clk) disable iff (rst)
        finish |-> txd);

    assert_load_when_free_R6: assert property (@(posedge clk) disable iff (rst)
        load |-> (!shifting || finish));

endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
    import dbuf_uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              tx_enable,
    input  logic              mode9,
    input  logic              bit8_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              done_clr,
    input  logic              ie_empty,
    input  logic              ie_done,
    input  logic              gie,
    output logic              txd,
    output logic              empty_flag,
    output logic              done_flag,
    output logic              irq_empty,
    output logic              irq_done
);

    tx_char_t wr_char;
    tx_char_t held;
    logic     load;
    logic     shifting;
    logic     finish;
    logic     tick;

    assign wr_char = '{nine: mode9, extra: bit8_in, payload: wr_data};

    dbuf_uart_tx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_char   (wr_char),
        .tx_enable (tx_enable),
        .shifting  (shifting),
        .finish    (finish),
        .done_clr  (done_clr),
        .load      (load),
        .q         (held),
        .empty     (empty_flag),
        .done      (done_flag)
    );

    dbuf_uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (shifting),
        .div  (baud_div),
        .tick (tick)
    );

    dbuf_uart_tx_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .ch       (held),
        .tick     (tick),
        .shifting (shifting),
        .finish   (finish),
        .txd      (txd)
    );

    assign irq_empty = empty_flag && ie_empty && gie;
    assign irq_done  = done_flag  && ie_done  && gie;

    assert_disabled_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (!tx_enable && empty_flag && !shifting && wr_en) |=> (empty_flag && txd));

    assert_finish_sets_or_loads_R7: assert property (@(posedge clk) disable iff (rst)
        finish |=> (done_flag || !empty_flag || shifting));

endmodule

// File: tb/dbuf_uart_tx_bench.sv
`timescale 1ns/1ps
module dbuf_uart_tx_bench;

    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] baud_div = '0;
    logic             tx_enable = 1'b0;
    logic             mode9 = 1'b0;
    logic             bit8_in = 1'b0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             done_clr = 1'b0;
    logic             ie_empty = 1'b0;
    logic             ie_done = 1'b0;
    logic             gie = 1'b0;
    logic             txd, empty_flag, done_flag, irq_empty, irq_done;

    dbuf_uart_tx #(.DIV_W(DIV_W)) u_dbuf_uart_tx (
        .clk(clk), .rst(rst), .baud_div(baud_div), .tx_enable(tx_enable),
        .mode9(mode9), .bit8_in(bit8_in), .wr_en(wr_en), .wr_data(wr_data),
        .done_clr(done_clr), .ie_empty(ie_empty), .ie_done(ie_done), .gie(gie),
        .txd(txd), .empty_flag(empty_flag), .done_flag(done_flag),
        .irq_empty(irq_empty), .irq_done(irq_done)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    bit summary_done = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Independent line receiver
    int         rx_div = 0;
    int         rx_len = 10;
    bit         m_act = 0;
    int         m_cnt = 0;
    int         m_start = 0;
    logic [10:0] m_bits;
    int          fr_stamp[$];
    logic [8:0]  fr_data[$];
    bit          fr_ok[$];

    always @(negedge clk) begin
        if (rst) begin
            m_act = 0;
        end else begin
            if (!m_act) begin
                if (txd === 1'b0) begin
                    m_act = 1; m_cnt = 0; m_start = cyc; m_bits = '1;
                end
            end else begin
                m_cnt++;
            end
            if (m_act && (m_cnt % (rx_div + 1)) == rx_div / 2) begin
                int idx;
                idx = m_cnt / (rx_div + 1);
                m_bits[idx] = txd;
                if (idx == rx_len - 1) begin
                    fr_stamp.push_back(m_start);
                    fr_data.push_back((rx_len == 11) ? m_bits[9:1] : {1'b0, m_bits[8:1]});
                    fr_ok.push_back(m_bits[0] == 1'b0 && m_bits[idx] == 1'b1);
                    m_act = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        end
    endtask

    task automatic clear_rx();
        fr_stamp.delete(); fr_data.delete(); fr_ok.delete();
    endtask

    task automatic write_char(input logic [8:0] v);
        wr_data = v[7:0]; bit8_in = v[8]; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 20000 && !empty_flag; i++) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && !done_flag; i++) @(negedge clk);
    endtask

    task automatic pulse_clr();
        done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    endtask

    // Streaming run: frames must match values and abut each other (R2, R3, R6)
    task automatic run_stream(input int div, input bit nine, input int count,
                              input int step, input int base);
        logic [8:0] exp_q[$];
        int len;
        len = nine ? 11 : 10;
        baud_div = DIV_W'(div); mode9 = nine; rx_div = div; rx_len = len;
        tx_enable = 1'b1;
        clear_rx();
        for (int k = 0; k < count; k++) begin
            logic [8:0] v;
            v = 9'((base + k * step) % (nine ? 512 : 256));
            wait_empty();
            write_char(v);
            exp_q.push_back(v);
        end
        wait_done();
        repeat (3 * (div + 1)) @(negedge clk);
        chk(fr_data.size() == count, nine ? "R3 frame count" : "R2 frame count",
            fr_data.size(), count);
        for (int k = 0; k < count && k < fr_data.size(); k++) begin
            chk(fr_data[k] == exp_q[k], nine ? "R3 ninth-bit frame data" : "R2 frame data",
                fr_data[k], exp_q[k]);
            chk(fr_ok[k], "R2 start/stop levels", fr_ok[k], 1);
            if (k > 0)
                chk(fr_stamp[k] - fr_stamp[k-1] == len * (div + 1), "R6 back-to-back spacing",
                    fr_stamp[k] - fr_stamp[k-1], len * (div + 1));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(empty_flag == 1'b1, "R1 empty_flag", empty_flag, 1);
        chk(done_flag == 1'b0, "R1 done_flag", done_flag, 0);
        chk(irq_empty == 1'b0 && irq_done == 1'b0, "R1 irq", {irq_empty, irq_done}, 0);

        // Exhaustive 8-bit at shortest bit, exhaustive 9-bit at div 1
        run_stream(0, 1'b0, 256, 1, 0);
        run_stream(1, 1'b1, 512, 1, 0);
        for (int d = 0; d <= 4; d++) run_stream(d, 1'b0, 16, 37, d * 11);
        run_stream(3, 1'b1, 12, 43, 300);

        // R4 latency, R5 empty timing, R7 done timing
        for (int d = 0; d <= 2; d++) begin
            int c, dcyc, len;
            len = 10;
            baud_div = DIV_W'(d); mode9 = 1'b0; rx_div = d; rx_len = len;
            tx_enable = 1'b1;
            pulse_clr();
            @(negedge clk);
            clear_rx();
            c = cyc;
            write_char(9'h0C5);
            chk(empty_flag == 1'b0, "R5 empty clears after write", empty_flag, 0);
            @(negedge clk);
            chk(empty_flag == 1'b1, "R5 empty sets on move to shifter", empty_flag, 1);
            chk(txd == 1'b0, "R4 start bit begins", txd, 0);
            wait_done();
            dcyc = cyc;
            chk(fr_stamp.size() == 1, "R4 one frame", fr_stamp.size(), 1);
            if (fr_stamp.size() == 1) begin
                chk(fr_stamp[0] == c + 2, "R4 start latency", fr_stamp[0], c + 2);
                chk(dcyc == fr_stamp[0] + len * (d + 1), "R7 done timing", dcyc,
                    fr_stamp[0] + len * (d + 1));
            end
            pulse_clr();
            chk(done_flag == 1'b0, "R7 done_clr", done_flag, 0);
        end

        // R8/R9 with both flags set (idle after a frame)
        wr_en = 1'b0;
        write_char(9'h011);
        wait_done();
        @(negedge clk);
        for (int m = 0; m < 8; m++) begin
            ie_empty = m[0]; ie_done = m[1]; gie = m[2];
            @(negedge clk);
            chk(irq_empty == (m[0] & m[2]), "R8 irq_empty with flag set", irq_empty, m[0] & m[2]);
            chk(irq_done == (m[1] & m[2]), "R9 irq_done with flag set", irq_done, m[1] & m[2]);
        end
        // R8/R9 with both flags clear (queued char while shifting)
        baud_div = DIV_W'(20); rx_div = 20; rx_len = 10;
        write_char(9'h0A0);
        @(negedge clk);
        write_char(9'h0A1);
        for (int m = 0; m < 8; m++) begin
            ie_empty = m[0]; ie_done = m[1]; gie = m[2];
            @(negedge clk);
            chk(irq_empty == 1'b0, "R8 irq_empty with flag clear", irq_empty, 0);
            chk(irq_done == 1'b0, "R9 irq_done with flag clear", irq_done, 0);
        end
        ie_empty = 0; ie_done = 0; gie = 0;
        wait_done();
        repeat (30) @(negedge clk);

        // R10 drain on disable
        baud_div = DIV_W'(3); rx_div = 3; rx_len = 10;
        pulse_clr();
        clear_rx();
        write_char(9'h0A5);
        @(negedge clk);
        write_char(9'h03C);
        tx_enable = 1'b0;
        wait_done();
        repeat (8) @(negedge clk);
        chk(fr_data.size() == 2, "R10 both characters drained", fr_data.size(), 2);
        if (fr_data.size() == 2) begin
            chk(fr_data[0] == 9'h0A5, "R10 first drained", fr_data[0], 9'h0A5);
            chk(fr_data[1] == 9'h03C, "R10 second drained", fr_data[1], 9'h03C);
        end
        chk(txd == 1'b1, "R10 idle after drain", txd, 1);

        // R11 write while disabled and drained
        clear_rx();
        write_char(9'h077);
        chk(empty_flag == 1'b1, "R11 empty unchanged", empty_flag, 1);
        begin
            int lows;
            lows = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (txd !== 1'b1) lows++;
            end
            chk(lows == 0, "R11 line held at mark", lows, 0);
        end
        chk(fr_data.size() == 0, "R11 no frame sent", fr_data.size(), 0);

        summary();
        $finish;
    end

endmodule